// File: doc/BRIEF.md
# Exception Entry and Vector Select Unit

This block performs the state update that a processor core makes when it takes an exception. A request arrives for one clock cycle. It carries either a direct exception code or a translation-fault kind, together with the coprocessor number, the faulting PC, a delay-slot flag, the access direction and the faulting virtual address. The block applies the request to its copies of the exception level flag, the cause fields, the exception PC, the bad-address register and the page-number fields of the three translation registers. It then emits a one-cycle redirect strobe that carries the 64-bit handler address.

For translation faults, the unit turns the fault kind and the access direction into an exception code. A refill fault that is taken from normal level goes to a separate handler. That handler sits at a different offset when the faulting region uses 64-bit addressing. A request that the unit cannot classify raises an error strobe instead of a redirect, and it changes no register.

The core's return path clears the exception level through a dedicated input. The core supplies the three per-mode 64-bit addressing enables from its status register.

Top module: `exc_entry_unit`

## Requirements
- R1: When a valid request is taken with `exc_level` low, `cause_bd` takes `exc_delay`, `epc` takes `exc_pc` (or `exc_pc - 4` when `exc_delay` is 1, wrapping modulo 2^64), and `exc_level` becomes 1.
- R2: When a request arrives with `exc_level` already 1, `epc` and `cause_bd` keep their values and `exc_level` stays 1.
- R3: Every valid request writes `exc_cop` into `cause_ce` and the final exception code into `cause_exc`.
- R4: Every valid request whose final code is not TLB load (2) or TLB store (3) redirects to 0xFFFFFFFF80000180. This includes TLB modification (1), interrupt (0), codes 4 to 13, floating-point (15) and watch (23).
- R5: A TLB load or store request redirects to 0xFFFFFFFF80000180 when `exc_level` was 1 before the request, or when it is a translation request (`exc_tlb`=1) with fault kind invalid (2).
- R6: Any other TLB load or store request redirects to 0xFFFFFFFF80000080 if 64-bit addressing applies, and to 0xFFFFFFFF80000000 if it does not. The choice uses bits 63:62 of the bad address, which is the new `fault_vaddr` for translation requests and the stored `badvaddr` for direct ones. 00 selects `stat_ux`, 01 selects `stat_sx`, 11 selects `stat_kx`, and 10 means no 64-bit addressing.
- R7: A valid translation request loads `badvaddr` with `fault_vaddr`, `ctx_vpn2` with address bits 31:13, `xctx_vpn2` and `ehi_vpn2` with bits 39:13, and `xctx_region` and `ehi_region` with bits 63:62. A direct request leaves all of these unchanged.
- R8: Fault kinds are encoded as 0 none, 1 miss, 2 invalid, 3 modification, 4 disallowed address. Miss and invalid map to code 2 on a load and code 3 on a store (`tlb_store`=1). Modification maps to code 1. Disallowed address maps to code 4 on a load and code 5 on a store.
- R9: A direct request with a code outside {0..13, 15, 23}, or a translation request with fault kind 0, 5, 6 or 7, pulses `req_err`. Such a request gives no redirect and leaves every exception register unchanged.
- R10: The redirect or error strobe is high in the cycle after the request cycle and only then. Requests in consecutive cycles each give their own strobe.
- R11: `exl_clr` clears `exc_level` in the following cycle. A valid request in the same cycle takes precedence, and `exc_level` ends at 1.
- R12: After reset, `exc_level`, `cause_bd`, `cause_ce`, `cause_exc`, the page-number and region fields and both strobes are 0, and `epc` and `badvaddr` are all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| exc_req | input | 1 | Exception request, one cycle |
| exc_code | input | 5 | Exception code for direct requests |
| exc_cop | input | 2 | Coprocessor number for the cause field |
| exc_pc | input | 64 | PC of the faulting instruction |
| exc_delay | input | 1 | Faulting instruction sits in a delay slot |
| exc_tlb | input | 1 | Request is a translation fault; code comes from `tlb_err` |
| tlb_err | input | 3 | Translation fault kind |
| tlb_store | input | 1 | Faulting access was a store |
| fault_vaddr | input | 64 | Faulting virtual address |
| stat_ux | input | 1 | 64-bit addressing enable, user region |
| stat_sx | input | 1 | 64-bit addressing enable, supervisor region |
| stat_kx | input | 1 | 64-bit addressing enable, kernel region |
| exl_clr | input | 1 | Return path: clear the exception level |
| exc_level | output | 1 | Exception level flag |
| cause_bd | output | 1 | Cause: delay-slot flag |
| cause_ce | output | 2 | Cause: coprocessor number |
| cause_exc | output | 5 | Cause: exception code |
| epc | output | 64 | Exception PC |
| badvaddr | output | 64 | Bad virtual address |
| ctx_vpn2 | output | 19 | Context page-pair number |
| xctx_vpn2 | output | 27 | Extended context page-pair number |
| xctx_region | output | 2 | Extended context region |
| ehi_vpn2 | output | 27 | Entry-high page-pair number |
| ehi_region | output | 2 | Entry-high region |
| redirect_vld | output | 1 | Redirect strobe |
| redirect_pc | output | 64 | Handler address, valid with the strobe |
| req_err | output | 1 | Unclassifiable request strobe |

## Verification
The hardest case to reach is the direct-code refill path. There, the 64-bit addressing choice depends on a stored bad address that only an earlier translation fault can set. The stimulus therefore interleaves a full sweep of translation faults over all four address regions and all eight enable patterns with direct code-2 and code-3 requests, so the stored region bits vary when direct requests arrive. Each sweep point also forces the exception level first, either through `exl_clr` or through a syscall request. A short sequence covers back-to-back requests and a request that coincides with `exl_clr`.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  // Exception codes recognised by the unit
  localparam logic [4:0] EC_INT   = 5'd0;
  localparam logic [4:0] EC_MOD   = 5'd1;
  localparam logic [4:0] EC_TLBL  = 5'd2;
  localparam logic [4:0] EC_TLBS  = 5'd3;
  localparam logic [4:0] EC_ADEL  = 5'd4;
  localparam logic [4:0] EC_ADES  = 5'd5;
  localparam logic [4:0] EC_TR    = 5'd13;
  localparam logic [4:0] EC_FPE   = 5'd15;
  localparam logic [4:0] EC_WATCH = 5'd23;

  typedef enum logic [2:0] {
    FK_NONE    = 3'd0,
    FK_MISS    = 3'd1,
    FK_INVALID = 3'd2,
    FK_MOD     = 3'd3,
    FK_BADADDR = 3'd4
  } fault_kind_e;

  typedef enum logic [1:0] {
    SEG_USER  = 2'b00,
    SEG_SUPV  = 2'b01,
    SEG_PHYS  = 2'b10,
    SEG_KERN  = 2'b11
  } seg_e;

  function automatic logic code_known(input logic [4:0] c);
    return (c <= EC_TR) || (c == EC_FPE) || (c == EC_WATCH);
  endfunction

  function automatic logic is_refill_code(input logic [4:0] c);
    return (c == EC_TLBL) || (c == EC_TLBS);
  endfunction

endpackage

// File: rtl/exc_rst_sync.sv
module exc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/exc_code_map.sv
module exc_code_map
  import exc_entry_pkg::*;
(
  input  logic       use_fault,
  input  logic [2:0] fault_kind,
  input  logic       is_store,
  input  logic [4:0] raw_code,
  output logic [4:0] code,
  output logic       known,
  output logic       kind_invalid
);
  fault_kind_e kind;

  always_comb begin
    kind         = fault_kind_e'(fault_kind);
    code         = raw_code;
    known        = 1'b0;
    kind_invalid = 1'b0;
    if (use_fault) begin
      unique case (kind)
        FK_MISS: begin
          code  = is_store ? EC_TLBS : EC_TLBL;
          known = 1'b1;
        end
        FK_INVALID: begin
          code         = is_store ? EC_TLBS : EC_TLBL;
          known        = 1'b1;
          kind_invalid = 1'b1;
        end
        FK_MOD: begin
          code  = EC_MOD;
          known = 1'b1;
        end
        FK_BADADDR: begin
          code  = is_store ? EC_ADES : EC_ADEL;
          known = 1'b1;
        end
        default: begin
          code  = EC_INT;
          known = 1'b0;
        end
      endcase
    end else begin
      known = code_known(raw_code);
    end
  end
endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
  import exc_entry_pkg::*;
#(
  parameter int          VA_W       = 64,
  parameter logic [31:0] VEC_BASE   = 32'h8000_0000,
  parameter logic [11:0] OFS_GEN    = 12'h180,
  parameter logic [11:0] OFS_XREFIL = 12'h080,
  parameter logic [11:0] OFS_REFIL  = 12'h000
) (
  input  logic [4:0]      code,
  input  logic            level_before,
  input  logic            kind_invalid,
  input  logic [1:0]      seg_bits,
  input  logic            en_user,
  input  logic            en_supv,
  input  logic            en_kern,
  output logic [VA_W-1:0] vector
);
  localparam int EXT_W = VA_W - 32;

  logic        wide_addr;
  logic [11:0] ofs;
  logic [31:0] vec32;

  always_comb begin
    unique case (seg_e'(seg_bits))
      SEG_USER: wide_addr = en_user;
      SEG_SUPV: wide_addr = en_supv;
      SEG_KERN: wide_addr = en_kern;
      default:  wide_addr = 1'b0;
    endcase

    if (!is_refill_code(code) || level_before || kind_invalid) ofs = OFS_GEN;
    else if (wide_addr)                                        ofs = OFS_XREFIL;
    else                                                       ofs = OFS_REFIL;

    vec32  = VEC_BASE | {20'd0, ofs};
    vector = {{EXT_W{vec32[31]}}, vec32};
  end
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs #(
  parameter int VA_W     = 64,
  parameter int PG_SHIFT = 13,
  parameter int CTX_W    = 19,
  parameter int XCTX_W   = 27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              take_fault,
  input  logic              level_clr,
  input  logic              in_delay,
  input  logic [1:0]        cop,
  input  logic [4:0]        code,
  input  logic [VA_W-1:0]   pc,
  input  logic [VA_W-1:0]   vaddr,
  output logic              level_q,
  output logic              bd_q,
  output logic [1:0]        ce_q,
  output logic [4:0]        code_q,
  output logic [VA_W-1:0]   epc_q,
  output logic [VA_W-1:0]   badv_q,
  output logic [CTX_W-1:0]  ctx_q,
  output logic [XCTX_W-1:0] xctx_q,
  output logic [1:0]        xreg_q,
  output logic [XCTX_W-1:0] ehi_q,
  output logic [1:0]        ereg_q
);
  localparam int SEG_LO = VA_W - 2;
  localparam logic [VA_W-1:0] SLOT_BYTES = VA_W'(4);

  logic              level_d, bd_d;
  logic [1:0]        ce_d, xreg_d, ereg_d;
  logic [4:0]        code_d;
  logic [VA_W-1:0]   epc_d, badv_d;
  logic [CTX_W-1:0]  ctx_d;
  logic [XCTX_W-1:0] xctx_d, ehi_d;

  // Next-state logic
  always_comb begin
    level_d = level_q;
    bd_d    = bd_q;
    ce_d    = ce_q;
    code_d  = code_q;
    epc_d   = epc_q;
    badv_d  = badv_q;
    ctx_d   = ctx_q;
    xctx_d  = xctx_q;
    xreg_d  = xreg_q;
    ehi_d   = ehi_q;
    ereg_d  = ereg_q;

    if (take) begin
      if (!level_q) begin
        bd_d    = in_delay;
        epc_d   = in_delay ? (pc - SLOT_BYTES) : pc;
        level_d = 1'b1;
      end
      ce_d   = cop;
      code_d = code;
    end else if (level_clr) begin
      level_d = 1'b0;
    end

    if (take_fault) begin
      badv_d = vaddr;
      ctx_d  = vaddr[PG_SHIFT +: CTX_W];
      xctx_d = vaddr[PG_SHIFT +: XCTX_W];
      xreg_d = vaddr[SEG_LO +: 2];
      ehi_d  = vaddr[PG_SHIFT +: XCTX_W];
      ereg_d = vaddr[SEG_LO +: 2];
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      bd_q    <= 1'b0;
      ce_q    <= '0;
      code_q  <= '0;
      epc_q   <= '1;
      badv_q  <= '1;
      ctx_q   <= '0;
      xctx_q  <= '0;
      xreg_q  <= '0;
      ehi_q   <= '0;
      ereg_q  <= '0;
    end else begin
      level_q <= level_d;
      bd_q    <= bd_d;
      ce_q    <= ce_d;
      code_q  <= code_d;
      epc_q   <= epc_d;
      badv_q  <= badv_d;
      ctx_q   <= ctx_d;
      xctx_q  <= xctx_d;
      xreg_q  <= xreg_d;
      ehi_q   <= ehi_d;
      ereg_q  <= ereg_d;
    end
  end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit #(
  parameter int VA_W     = 64,
  parameter int PG_SHIFT = 13,
  parameter int CTX_W    = 19,
  parameter int XCTX_W   = 27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_req,
  input  logic [4:0]        exc_code,
  input  logic [1:0]        exc_cop,
  input  logic [VA_W-1:0]   exc_pc,
  input  logic              exc_delay,
  input  logic              exc_tlb,
  input  logic [2:0]        tlb_err,
  input  logic              tlb_store,
  input  logic [VA_W-1:0]   fault_vaddr,
  input  logic              stat_ux,
  input  logic              stat_sx,
  input  logic              stat_kx,
  input  logic              exl_clr,
  output logic              exc_level,
  output logic              cause_bd,
  output logic [1:0]        cause_ce,
  output logic [4:0]        cause_exc,
  output logic [VA_W-1:0]   epc,
  output logic [VA_W-1:0]   badvaddr,
  output logic [CTX_W-1:0]  ctx_vpn2,
  output logic [XCTX_W-1:0] xctx_vpn2,
  output logic [1:0]        xctx_region,
  output logic [XCTX_W-1:0] ehi_vpn2,
  output logic [1:0]        ehi_region,
  output logic              redirect_vld,
  output logic [VA_W-1:0]   redirect_pc,
  output logic              req_err
);
  localparam int SEG_LO = VA_W - 2;

  logic            rst_n_i;
  logic [4:0]      fin_code;
  logic            code_ok, kind_inv;
  logic            take, take_fault;
  logic [1:0]      seg_bits;
  logic [VA_W-1:0] vec;

  logic            redir_d, redir_q, err_d, err_q;
  logic [VA_W-1:0] rpc_d, rpc_q;

  exc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  exc_code_map u_map (
    .use_fault    (exc_tlb),
    .fault_kind   (tlb_err),
    .is_store     (tlb_store),
    .raw_code     (exc_code),
    .code         (fin_code),
    .known        (code_ok),
    .kind_invalid (kind_inv)
  );

  assign take       = exc_req && code_ok;
  assign take_fault = take && exc_tlb;
  assign seg_bits   = exc_tlb ? fault_vaddr[SEG_LO +: 2] : badvaddr[SEG_LO +: 2];

  exc_vector_sel #(.VA_W(VA_W)) u_vec (
    .code         (fin_code),
    .level_before (exc_level),
    .kind_invalid (kind_inv),
    .seg_bits     (seg_bits),
    .en_user      (stat_ux),
    .en_supv      (stat_sx),
    .en_kern      (stat_kx),
    .vector       (vec)
  );

  exc_state_regs #(
    .VA_W     (VA_W),
    .PG_SHIFT (PG_SHIFT),
    .CTX_W    (CTX_W),
    .XCTX_W   (XCTX_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .take       (take),
    .take_fault (take_fault),
    .level_clr  (exl_clr),
    .in_delay   (exc_delay),
    .cop        (exc_cop),
    .code       (fin_code),
    .pc         (exc_pc),
    .vaddr      (fault_vaddr),
    .level_q    (exc_level),
    .bd_q       (cause_bd),
    .ce_q       (cause_ce),
    .code_q     (cause_exc),
    .epc_q      (epc),
    .badv_q     (badvaddr),
    .ctx_q      (ctx_vpn2),
    .xctx_q     (xctx_vpn2),
    .xreg_q     (xctx_region),
    .ehi_q      (ehi_vpn2),
    .ereg_q     (ehi_region)
  );

  // Redirect / error strobe next state
  always_comb begin
    redir_d = take;
    err_d   = exc_req && !code_ok;
    rpc_d   = take ? vec : rpc_q;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      redir_q <= 1'b0;
      err_q   <= 1'b0;
      rpc_q   <= '0;
    end else begin
      redir_q <= redir_d;
      err_q   <= err_d;
      rpc_q   <= rpc_d;
    end
  end

  assign redirect_vld = redir_q;
  assign redirect_pc  = rpc_q;
  assign req_err      = err_q;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int VA_W = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            exc_req,
  input logic [1:0]      exc_cop,
  input logic [VA_W-1:0] exc_pc,
  input logic            exc_delay,
  input logic            exl_clr,
  input logic            exc_level,
  input logic            cause_bd,
  input logic [1:0]      cause_ce,
  input logic [4:0]      cause_exc,
  input logic [VA_W-1:0] epc,
  input logic [VA_W-1:0] badvaddr,
  input logic            redirect_vld,
  input logic [VA_W-1:0] redirect_pc,
  input logic            req_err
);
  a_r1_level_set: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_vld |-> exc_level);

  a_r1_epc_plain: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && !exc_level && !exc_delay) |=> (!redirect_vld || epc == $past(exc_pc)));

  a_r2_epc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && exc_level) |=> ($stable(epc) && $stable(cause_bd)));

  a_r3_cop_field: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_vld |-> (cause_ce == $past(exc_cop)));

  a_r4_vec_high: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_vld |-> (redirect_pc[VA_W-1:12] == {{(VA_W-32){1'b1}}, 20'h80000}));

  a_r9_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> ($stable(epc) && $stable(badvaddr) && $stable(cause_exc) && $stable(cause_ce)));

  a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |=> (redirect_vld != req_err));

  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_req |=> (!redirect_vld && !req_err));

  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (exl_clr && !exc_req) |=> !exc_level);
endmodule

bind exc_entry_unit exc_entry_chk #(.VA_W(VA_W)) chk_i (.*);

// File: tb/exc_entry_unit_tb_top.sv
module exc_entry_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        exc_req, exc_delay, exc_tlb, tlb_store, stat_ux, stat_sx, stat_kx, exl_clr;
  logic [4:0]  exc_code;
  logic [1:0]  exc_cop;
  logic [2:0]  tlb_err;
  logic [63:0] exc_pc, fault_vaddr;
  logic        exc_level, cause_bd, redirect_vld, req_err;
  logic [1:0]  cause_ce, xctx_region, ehi_region;
  logic [4:0]  cause_exc;
  logic [63:0] epc, badvaddr, redirect_pc;
  logic [18:0] ctx_vpn2;
  logic [26:0] xctx_vpn2, ehi_vpn2;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // model state
  logic        m_lvl, m_bd;
  logic [1:0]  m_ce, m_xr;
  logic [4:0]  m_code;
  logic [63:0] m_epc, m_badv;
  logic [18:0] m_ctx;
  logic [26:0] m_xctx;

  always #5 clk = ~clk;

  exc_entry_unit dut_i (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic known_code(input logic [4:0] c);
    return (c <= 5'd13) || (c == 5'd15) || (c == 5'd23);
  endfunction

  task automatic check_regs(input string tag);
    check({tag, " R1/R2 level"}, 64'(exc_level), 64'(m_lvl));
    check({tag, " R1/R2 epc"}, epc, m_epc);
    check({tag, " R1/R2 bd"}, 64'(cause_bd), 64'(m_bd));
    check({tag, " R3 ce"}, 64'(cause_ce), 64'(m_ce));
    check({tag, " R3 exc"}, 64'(cause_exc), 64'(m_code));
    check({tag, " R7 badv"}, badvaddr, m_badv);
    check({tag, " R7 ctx"}, 64'(ctx_vpn2), 64'(m_ctx));
    check({tag, " R7 xctx"}, 64'(xctx_vpn2), 64'(m_xctx));
    check({tag, " R7 ehi"}, 64'(ehi_vpn2), 64'(m_xctx));
    check({tag, " R7 xreg"}, 64'(xctx_region), 64'(m_xr));
    check({tag, " R7 ereg"}, 64'(ehi_region), 64'(m_xr));
  endtask

  // Drive one request at a negedge, sample at the next negedge.
  task automatic do_req(input logic [4:0] code, input logic [1:0] cop, input logic [63:0] pc,
                        input logic dly, input logic tlb, input logic [2:0] kind,
                        input logic st, input logic [63:0] va, input logic [2:0] stat);
    logic        ok, inv, wide;
    logic [4:0]  fc;
    logic [1:0]  seg;
    logic [63:0] vec;
    string       vtag;
    ok = 1'b0; inv = 1'b0; fc = code;
    if (tlb) begin
      case (kind)
        3'd1: begin fc = st ? 5'd3 : 5'd2; ok = 1'b1; end
        3'd2: begin fc = st ? 5'd3 : 5'd2; ok = 1'b1; inv = 1'b1; end
        3'd3: begin fc = 5'd1; ok = 1'b1; end
        3'd4: begin fc = st ? 5'd5 : 5'd4; ok = 1'b1; end
        default: ok = 1'b0;
      endcase
    end else ok = known_code(code);
    seg = tlb ? va[63:62] : m_badv[63:62];
    case (seg)
      2'b00: wide = stat[0];
      2'b01: wide = stat[1];
      2'b11: wide = stat[2];
      default: wide = 1'b0;
    endcase
    if (!(fc == 5'd2 || fc == 5'd3)) begin vec = 64'hFFFF_FFFF_8000_0180; vtag = "R4 vector"; end
    else if (m_lvl || inv)        begin vec = 64'hFFFF_FFFF_8000_0180; vtag = "R5 vector"; end
    else if (wide)                begin vec = 64'hFFFF_FFFF_8000_0080; vtag = "R6 vector"; end
    else                          begin vec = 64'hFFFF_FFFF_8000_0000; vtag = "R6 vector"; end

    exc_req = 1'b1; exc_code = code; exc_cop = cop; exc_pc = pc; exc_delay = dly;
    exc_tlb = tlb; tlb_err = kind; tlb_store = st; fault_vaddr = va;
    {stat_kx, stat_sx, stat_ux} = stat;
    @(posedge clk);
    @(negedge clk);
    exc_req = 1'b0;

    if (ok) begin
      if (!m_lvl) begin
        m_bd = dly; m_epc = dly ? pc - 64'd4 : pc; m_lvl = 1'b1;
      end
      m_ce = cop; m_code = fc;
      if (tlb) begin
        m_badv = va; m_ctx = va[31:13]; m_xctx = va[39:13]; m_xr = va[63:62];
      end
    end
    check("R10 redirect", 64'(redirect_vld), 64'(ok));
    check("R9 err", 64'(req_err), 64'(!ok));
    if (ok) check(vtag, redirect_pc, vec);
    if (ok && tlb) check("R8 mapped code", 64'(cause_exc), 64'(fc));
    check_regs(ok ? "valid" : "R9 rejected");
  endtask

  task automatic set_level(input logic want);
    if (want && !m_lvl) do_req(5'd8, 2'd0, 64'h1000, 1'b0, 1'b0, 3'd0, 1'b0, 64'd0, 3'd0);
    if (!want && m_lvl) begin
      exl_clr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      exl_clr = 1'b0;
      m_lvl = 1'b0;
      check("R11 clear", 64'(exc_level), 64'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    exc_req = 0; exc_code = 0; exc_cop = 0; exc_pc = 0; exc_delay = 0; exc_tlb = 0;
    tlb_err = 0; tlb_store = 0; fault_vaddr = 0; stat_ux = 0; stat_sx = 0; stat_kx = 0; exl_clr = 0;
    m_lvl = 0; m_bd = 0; m_ce = 0; m_xr = 0; m_code = 0; m_epc = '1; m_badv = '1; m_ctx = 0; m_xctx = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    check_regs("R12 reset");
    check("R12 redirect", 64'(redirect_vld), 64'd0);
    check("R12 err", 64'(req_err), 64'd0);

    // Direct-code sweep interleaved with a fault that changes the stored region
    for (int c = 0; c < 32; c++) begin
      for (int l = 0; l < 2; l++) begin
        for (int d = 0; d < 2; d++) begin
          do_req(5'd0, 2'(c), 64'(c) << 60, 1'b0, 1'b1, 3'd1, 1'b0,
                 {2'(c + d), 62'h0123_4567_89AB_CDEF}, 3'd0);
          set_level(l[0]);
          do_req(5'(c), 2'(c + 1), 64'hFFFF_FFFF_8000_0400 + 64'(c * 16), d[0], 1'b0,
                 3'd0, 1'b0, 64'd0, 3'(c + l));
        end
      end
    end

    // PC wrap in a delay slot (R1)
    set_level(1'b0);
    do_req(5'd8, 2'd1, 64'd0, 1'b1, 1'b0, 3'd0, 1'b0, 64'd0, 3'd0);
    check("R1 wrap epc", epc, 64'hFFFF_FFFF_FFFF_FFFC);

    // Translation-fault sweep
    for (int k = 0; k < 8; k++)
      for (int s = 0; s < 2; s++)
        for (int l = 0; l < 2; l++)
          for (int r = 0; r < 4; r++)
            for (int e = 0; e < 8; e++) begin
              set_level(l[0]);
              do_req(5'd31, 2'(e), 64'h0000_0000_0040_0000 + 64'(k * 64 + e * 4), e[0], 1'b1,
                     3'(k), s[0], {2'(r), 62'(64'h0ABC_DEF0_1234_5678 * 64'(k * 32 + e + 1))}, 3'(e));
            end

    // Same-cycle clear and request: request wins (R11)
    set_level(1'b0);
    exl_clr = 1'b1;
    do_req(5'd12, 2'd2, 64'h2000, 1'b0, 1'b0, 3'd0, 1'b0, 64'd0, 3'd0);
    exl_clr = 1'b0;
    check("R11 request wins", 64'(exc_level), 64'd1);

    // Back-to-back requests: two strobes, second keeps the first EPC (R10, R2)
    set_level(1'b0);
    exc_req = 1'b1; exc_tlb = 1'b0; exc_code = 5'd9; exc_cop = 2'd1; exc_pc = 64'h3000; exc_delay = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R10 first strobe", 64'(redirect_vld), 64'd1);
    exc_code = 5'd10; exc_pc = 64'h4000;
    @(posedge clk);
    @(negedge clk);
    exc_req = 1'b0;
    check("R10 second strobe", 64'(redirect_vld), 64'd1);
    check("R2 back-to-back epc", epc, 64'h3000);
    check("R3 back-to-back exc", 64'(cause_exc), 64'd10);
    @(posedge clk);
    @(negedge clk);
    check("R10 strobe drops", 64'(redirect_vld), 64'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule